// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Refresh and Unlock

This block supervises software by counting ticks of a slow, selectable timing source and raising a one-cycle reset request when the count reaches a programmed limit. Software keeps the system alive by writing a two-word refresh key to the key register. Both words of the key must arrive within a short gap of bus clocks; a wrong second word or a gap that runs out is treated as a software fault and also raises the reset request.

Configuration (control, timeout limit, window limit) can be written once after reset. A later change needs a two-word unlock key, after which every configuration register stays writable for a bounded number of bus clocks. An optional divide-by-256 prefilter stretches the timeout, a window mode rejects refreshes that come too early, and two test modes let the limit check look at one byte of the counter so that a test finishes in a few ticks. The timing sources are sampled through synchronizers in the bus clock domain, and a rising edge of the chosen source is one tick.

Register addresses on `wr_addr`: 0 control, 1 timeout limit, 2 window limit, 3 key. Control bits: bit 0 enable, bit 1 divide-by-256, bit 2 window mode, bits 4:3 test mode (0 or 3 full compare, 1 low byte, 2 high byte).

Top module: `wdt_window_guard`

## Requirements
- R1: After reset `rst_req` is low; with full compare, no prescaler and limit T, the reset request is a one-cycle pulse after the T-th tick, and counting then restarts from zero so the next pulse follows T further ticks.
- R2: Writing 0x02A6 and then 0x80B4 to the key register (address 3), with the second write at most 16 bus clocks after the first, clears the count without a reset request.
- R3: While the block is enabled, a refresh sequence whose second word is not 0x80B4, or whose second word does not arrive within 16 bus clocks, raises one reset request; a lone 0x80B4 written with no sequence open is ignored.
- R4: Writing 0x20C5 and then 0x28D9 to the key register within 16 bus clocks makes all three configuration registers writable for the following 128 bus clocks; a late second word opens nothing and raises no reset.
- R5: Each configuration register (addresses 0, 1, 2) accepts only its first write after reset while no unlock is open; later writes leave the programmed behaviour unchanged.
- R6: With control bit 1 set, the counter advances once per 256 ticks, so limit T gives a reset after 256*T ticks.
- R7: With control bit 2 set, a valid refresh arriving while the count is below the window limit raises a reset request; a refresh at a count equal to or above it is accepted.
- R8: `clk_sel` selects the tick source: 0 `src_clk[0]`, 1 `src_clk[1]`, 2 or 3 `src_clk[2]`; edges on other sources have no effect on the count.
- R9: Test mode 1 advances the counter by one and compares only bits 7:0 with the limit; test mode 2 advances it by 256 and compares only bits 15:8, so the reset follows the compared byte's value in ticks.
- R10: When a valid refresh is taken in the same cycle as the tick that would reach the limit, the refresh wins: no reset request, and the count restarts from zero.
- R11: With control bit 0 clear the counter is held at zero and no reset request is raised, whatever ticks or key writes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| clk_sel | input | 2 | Tick source select |
| src_clk | input | 3 | Slow timing sources (two internal, one external) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The sharpest collision is the second refresh word being taken in the same bus cycle as the tick that brings the counter to its limit. The bench raises a source edge one cycle before it writes 0x80B4, so the synchronized tick and the refresh acknowledge land on one edge, and then judges that no reset pulse appears and that a full limit of further ticks is needed for the next one. The window check meets the same path: early and late refreshes are placed at counts just below, at and above the window limit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW = 16;
    localparam int AW = 2;
    localparam int HB = DW / 2;

    localparam logic [AW-1:0] A_CTRL = 2'd0;
    localparam logic [AW-1:0] A_TOUT = 2'd1;
    localparam logic [AW-1:0] A_WIN  = 2'd2;
    localparam logic [AW-1:0] A_KEY  = 2'd3;

    localparam logic [DW-1:0] KEY_REF_A = 16'h02A6;
    localparam logic [DW-1:0] KEY_REF_B = 16'h80B4;
    localparam logic [DW-1:0] KEY_UNL_A = 16'h20C5;
    localparam logic [DW-1:0] KEY_UNL_B = 16'h28D9;

    typedef enum logic [1:0] {
        TM_FULL = 2'd0,
        TM_LOW  = 2'd1,
        TM_HIGH = 2'd2,
        TM_ALT  = 2'd3
    } tmode_e;

    typedef struct packed {
        tmode_e tmode;
        logic   win_en;
        logic   div256;
        logic   en;
    } ctrl_t;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_REF  = 2'd1,
        KS_UNL  = 2'd2
    } kstate_e;
endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
    parameter int NSRC   = 3,
    parameter int SEL_W  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NSRC - 1);

    typedef struct packed {
        logic [NSRC-1:0][STAGES-1:0] chain;
        logic                        prev;
    } st_t;

    st_t q, d;
    logic [SEL_W-1:0] idx;
    logic             picked;

    always_comb begin
        d = q;
        for (int i = 0; i < NSRC; i++) begin
            d.chain[i] = {q.chain[i][STAGES-2:0], src[i]};
        end
        idx    = (sel > LAST) ? LAST : sel;
        picked = q.chain[idx][STAGES-1];
        d.prev = picked;
        tick   = picked && !q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int GAP   = 16,
    localparam int GW   = $clog2(GAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    output logic          ref_ack,
    output logic          ref_bad,
    output logic          unl_ok
);
    typedef struct packed {
        kstate_e       st;
        logic [GW-1:0] gap;
        logic          ack;
        logic          bad;
        logic          unl;
    } st_t;

    st_t q, d;
    logic gap_out;

    assign gap_out = (q.gap == GW'(GAP - 1));

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        d.bad = 1'b0;
        d.unl = 1'b0;
        case (q.st)
            KS_IDLE: begin
                if (key_wr && key_data == KEY_REF_A) begin
                    d.st  = KS_REF;
                    d.gap = '0;
                end else if (key_wr && key_data == KEY_UNL_A) begin
                    d.st  = KS_UNL;
                    d.gap = '0;
                end
            end
            KS_REF: begin
                if (key_wr) begin
                    d.st  = KS_IDLE;
                    d.ack = (key_data == KEY_REF_B);
                    d.bad = (key_data != KEY_REF_B);
                end else if (gap_out) begin
                    d.st  = KS_IDLE;
                    d.bad = 1'b1;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            KS_UNL: begin
                if (key_wr) begin
                    d.st  = KS_IDLE;
                    d.unl = (key_data == KEY_UNL_B);
                end else if (gap_out) begin
                    d.st  = KS_IDLE;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            default: d.st = KS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: KS_IDLE, gap: '0, ack: 1'b0, bad: 1'b0, unl: 1'b0};
        else        q <= d;
    end

    assign ref_ack = q.ack;
    assign ref_bad = q.bad;
    assign unl_ok  = q.unl;

    // R3
    gap_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == KS_REF && !key_wr && gap_out) |=> ref_bad);

    // R2
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_ack, ref_bad, unl_ok}));
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_pkg::*;
#(
    parameter int            UNLOCK_CYC  = 128,
    parameter logic [DW-1:0] DEF_TIMEOUT = 16'hFFFF,
    localparam int           UW          = $clog2(UNLOCK_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          unl_ok,
    output ctrl_t         ctrl,
    output logic [DW-1:0] timeout,
    output logic [DW-1:0] window
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] tout;
        logic [DW-1:0] win;
        logic [2:0]    done;
        logic [UW-1:0] ucnt;
        logic          uopen;
    } st_t;

    localparam st_t RST = '{
        ctrl: '{tmode: TM_FULL, win_en: 1'b0, div256: 1'b0, en: 1'b1},
        tout: DEF_TIMEOUT, win: '0, done: '0, ucnt: '0, uopen: 1'b0};

    st_t  q, d;
    logic unused_hi;
    logic may_ctrl, may_tout, may_win;

    assign unused_hi = ^wr_data[DW-1:5];
    assign may_ctrl  = wr_en && wr_addr == A_CTRL && (!q.done[0] || q.uopen);
    assign may_tout  = wr_en && wr_addr == A_TOUT && (!q.done[1] || q.uopen);
    assign may_win   = wr_en && wr_addr == A_WIN  && (!q.done[2] || q.uopen);

    always_comb begin
        d = q;
        if (unl_ok) begin
            d.uopen = 1'b1;
            d.ucnt  = '0;
        end else if (q.uopen) begin
            if (q.ucnt == UW'(UNLOCK_CYC - 1)) d.uopen = 1'b0;
            else                               d.ucnt  = q.ucnt + 1'b1;
        end
        if (may_ctrl) begin
            d.ctrl    = ctrl_t'(wr_data[4:0]);
            d.done[0] = 1'b1;
        end
        if (may_tout) begin
            d.tout    = wr_data;
            d.done[1] = 1'b1;
        end
        if (may_win) begin
            d.win     = wr_data;
            d.done[2] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign ctrl    = q.ctrl;
    assign timeout = q.tout;
    assign window  = q.win;

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TOUT && q.done[1] && !q.uopen) |=> $stable(timeout));

    // R4
    unlock_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.uopen |-> (q.ucnt < UW'(UNLOCK_CYC)));
endmodule

// File: rtl/wdt_window_guard.sv
module wdt_window_guard
    import wdt_pkg::*;
#(
    parameter int            NSRC        = 3,
    parameter int            SEL_W       = 2,
    parameter int            SYNC_STAGES = 2,
    parameter int            PRE_W       = 8,
    parameter int            GAP         = 16,
    parameter int            UNLOCK_CYC  = 128,
    parameter logic [DW-1:0] DEF_TIMEOUT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [NSRC-1:0]  src_clk,
    output logic             rst_req
);
    localparam logic [DW-1:0] STEP_LO = DW'(1);
    localparam logic [DW-1:0] STEP_HI = DW'(1) << HB;

    typedef struct packed {
        logic [DW-1:0]    cnt;
        logic [PRE_W-1:0] pre;
        logic             rst;
    } st_t;

    st_t           q, d;
    logic          tick, ref_ack, ref_bad, unl_ok;
    ctrl_t         ctrl;
    logic [DW-1:0] timeout, window, nxt;
    logic          adv, hit, early, good_ref, expire;

    wdt_tick_sync #(.NSRC(NSRC), .SEL_W(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .src(src_clk), .sel(clk_sel), .tick(tick));

    wdt_key_seq #(.GAP(GAP)) u_keys (
        .clk(clk), .rst_n(rst_n), .key_wr(wr_en && wr_addr == A_KEY),
        .key_data(wr_data), .ref_ack(ref_ack), .ref_bad(ref_bad), .unl_ok(unl_ok));

    wdt_cfg #(.UNLOCK_CYC(UNLOCK_CYC), .DEF_TIMEOUT(DEF_TIMEOUT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .unl_ok(unl_ok), .ctrl(ctrl), .timeout(timeout), .window(window));

    assign nxt      = q.cnt + ((ctrl.tmode == TM_HIGH) ? STEP_HI : STEP_LO);
    assign adv      = tick && (!ctrl.div256 || q.pre == '1);
    assign early    = ref_ack && ctrl.win_en && (q.cnt < window);
    assign good_ref = ref_ack && !early;
    assign expire   = adv && hit && !good_ref;

    always_comb begin
        case (ctrl.tmode)
            TM_LOW:  hit = (nxt[HB-1:0] == timeout[HB-1:0]);
            TM_HIGH: hit = (nxt[DW-1:HB] == timeout[DW-1:HB]);
            default: hit = (nxt == timeout);
        endcase
    end

    always_comb begin
        d     = q;
        d.rst = 1'b0;
        if (!ctrl.en) begin
            d.cnt = '0;
            d.pre = '0;
        end else if (ref_bad || early || expire) begin
            d.rst = 1'b1;
            d.cnt = '0;
            d.pre = '0;
        end else if (good_ref) begin
            d.cnt = '0;
            d.pre = '0;
        end else begin
            if (tick && ctrl.div256) d.pre = q.pre + 1'b1;
            if (adv)                 d.cnt = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rst_req = q.rst;

    // R1
    rst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (q.cnt == '0 && q.pre == '0));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |=> !rst_req);

    // R10
    ref_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_ref && ctrl.en) |=> (!rst_req && q.cnt == '0));

    // R7
    early_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (early && ctrl.en) |=> rst_req);
endmodule

// File: tb/tb_wdt_window_guard.sv
module tb_wdt_window_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  clk_sel = '0;
    logic [2:0]  src_clk = '0;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    int npulse = 0;
    int base = 0;
    bit done = 1'b0;

    wdt_window_guard dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clk_sel(clk_sel), .src_clk(src_clk), .rst_req(rst_req));

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) if (rst_req) npulse++;

    function automatic int exp_ticks(input logic [4:0] c, input logic [15:0] t);
        int n;
        case (c[4:3])
            2'd1:    n = int'(t[7:0]);
            2'd2:    n = int'(t[15:8]);
            default: n = int'(t);
        endcase
        if (c[1]) n = n * 256;
        return n;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n, input int s);
        for (int i = 0; i < n; i++) begin
            src_clk[s] = 1'b1;
            idle(4);
            src_clk[s] = 1'b0;
            idle(4);
        end
    endtask

    task automatic refresh();
        wr(2'd3, 16'h02A6);
        wr(2'd3, 16'h80B4);
        idle(2);
    endtask

    task automatic unlock();
        wr(2'd3, 16'h20C5);
        wr(2'd3, 16'h28D9);
        idle(2);
    endtask

    task automatic configure(input logic [4:0] c, input logic [15:0] t, input logic [15:0] w);
        unlock();
        wr(2'd0, {11'd0, c & 5'b11011});
        wr(2'd1, t);
        wr(2'd2, w);
        refresh();
        if (c[2]) wr(2'd0, {11'd0, c});
        idle(2);
        base = npulse;
    endtask

    function automatic int got();
        return npulse - base;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20714);
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk(int'(rst_req), 0, "R1 reset state");

        wr(2'd0, 16'h0001);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd0);
        refresh();
        base = npulse;
        tick(4, 0);
        chk(got(), 0, "R1 before limit");
        tick(1, 0);
        chk(got(), 1, "R1 at limit");
        tick(4, 0);
        chk(got(), 1, "R1 restart");
        tick(1, 0);
        chk(got(), 2, "R1 second period");

        base = npulse;
        wr(2'd1, 16'd2);
        tick(4, 0);
        chk(got(), 0, "R5 locked timeout write ignored");
        tick(1, 0);
        chk(got(), 1, "R5 old limit kept");

        base = npulse;
        tick(3, 0);
        refresh();
        tick(4, 0);
        chk(got(), 0, "R2 refresh clears count");
        tick(1, 0);
        chk(got(), 1, "R2 full period after refresh");

        base = npulse;
        tick(2, 0);
        wr(2'd3, 16'h02A6);
        wr(2'd3, 16'h1234);
        idle(2);
        chk(got(), 1, "R3 wrong second word");
        tick(4, 0);
        chk(got(), 1, "R3 count cleared by fault");
        tick(1, 0);
        chk(got(), 2, "R3 next period");

        base = npulse;
        wr(2'd3, 16'h02A6);
        idle(20);
        chk(got(), 1, "R3 gap expiry");
        wr(2'd3, 16'h80B4);
        idle(2);
        chk(got(), 1, "R3 lone second word ignored");

        base = npulse;
        tick(4, 0);
        wr(2'd3, 16'h02A6);
        idle(15);
        wr(2'd3, 16'h80B4);
        idle(2);
        tick(4, 0);
        chk(got(), 0, "R2 gap of 16 accepted");
        tick(1, 0);
        chk(got(), 1, "R2 gap of 16 period");

        base = npulse;
        wr(2'd3, 16'h02A6);
        idle(16);
        wr(2'd3, 16'h80B4);
        idle(2);
        chk(got(), 1, "R3 gap of 17 rejected");

        configure(5'b00001, 16'd3, 16'd0);
        tick(2, 0);
        chk(got(), 0, "R4 unlocked write taken");
        tick(1, 0);
        chk(got(), 1, "R4 new limit");
        base = npulse;
        idle(140);
        wr(2'd1, 16'd9);
        tick(2, 0);
        chk(got(), 0, "R4 relocked window");
        tick(1, 0);
        chk(got(), 1, "R4 write after window ignored");
        base = npulse;
        wr(2'd3, 16'h20C5);
        idle(16);
        wr(2'd3, 16'h28D9);
        idle(2);
        chk(got(), 0, "R4 late unlock raises no reset");
        wr(2'd1, 16'd9);
        tick(3, 0);
        chk(got(), 1, "R4 late unlock opens nothing");

        configure(5'b00011, 16'd2, 16'd0);
        tick(511, 0);
        chk(got(), 0, "R6 prescaled before limit");
        tick(1, 0);
        chk(got(), 1, "R6 prescaled limit");

        configure(5'b01001, 16'h1203, 16'd0);
        tick(2, 0);
        chk(got(), 0, "R9 low byte before");
        tick(1, 0);
        chk(got(), 1, "R9 low byte limit");
        configure(5'b10001, 16'h0407, 16'd0);
        tick(3, 0);
        chk(got(), 0, "R9 high byte before");
        tick(1, 0);
        chk(got(), 1, "R9 high byte limit");

        configure(5'b00001, 16'd4, 16'd0);
        clk_sel = 2'd1;
        idle(4);
        tick(10, 0);
        tick(10, 2);
        chk(got(), 0, "R8 unselected sources ignored");
        tick(3, 1);
        chk(got(), 0, "R8 selected before");
        tick(1, 1);
        chk(got(), 1, "R8 selected limit");
        clk_sel = 2'd3;
        idle(4);
        base = npulse;
        tick(4, 2);
        chk(got(), 1, "R8 select 3 uses source 2");
        clk_sel = 2'd0;
        idle(4);

        configure(5'b00101, 16'd10, 16'd6);
        tick(3, 0);
        refresh();
        chk(got(), 1, "R7 early refresh");
        tick(6, 0);
        refresh();
        chk(got(), 1, "R7 refresh at window limit");
        tick(7, 0);
        refresh();
        tick(9, 0);
        chk(got(), 1, "R7 late refresh accepted");
        tick(1, 0);
        chk(got(), 2, "R7 limit after late refresh");

        configure(5'b00001, 16'd5, 16'd0);
        tick(4, 0);
        wr(2'd3, 16'h02A6);
        src_clk[0] = 1'b1;
        idle(1);
        wr(2'd3, 16'h80B4);
        idle(2);
        src_clk[0] = 1'b0;
        idle(4);
        chk(got(), 0, "R10 refresh beats final tick");
        tick(4, 0);
        chk(got(), 0, "R10 count restarted");
        tick(1, 0);
        chk(got(), 1, "R10 next limit");

        configure(5'b00000, 16'd3, 16'd0);
        tick(20, 0);
        wr(2'd3, 16'h02A6);
        wr(2'd3, 16'h5555);
        wr(2'd3, 16'h02A6);
        idle(20);
        chk(got(), 0, "R11 disabled stays quiet");
        configure(5'b00001, 16'd3, 16'd0);
        tick(3, 0);
        chk(got(), 1, "R11 enabled again counts from zero");

        for (int it = 0; it < 40; it++) begin
            logic [4:0]  c;
            logic [15:0] t;
            int n, k;
            c = {2'($urandom_range(0, 2)), 3'b001};
            case (c[4:3])
                2'd1:    t = {8'($urandom), 8'($urandom_range(2, 12))};
                2'd2:    t = {8'($urandom_range(2, 12)), 8'($urandom)};
                default: t = 16'($urandom_range(2, 12));
            endcase
            n = exp_ticks(c, t);
            k = $urandom_range(1, n - 1);
            configure(c, t, 16'd0);
            tick(k, 0);
            refresh();
            tick(n - 1, 0);
            chk(got(), 0, "R2 random refresh then run");
            tick(1, 0);
            chk(got(), 1, "R1 random limit");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule